// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block prepares the second ALU operand. It takes a 32-bit value and shifts or rotates it by an amount that comes either from a small immediate field or from a register. The shift kinds are logical left, logical right, arithmetic right, rotate right, and a one-place rotate through the carry flag. Along with the shifted operand, the block returns a carry-out that follows the instruction set's rules. For a normal shift this is the last bit pushed out of the word. Shift amounts of zero, of exactly the word width, and above the word width each have their own carry rule.

The block is purely combinational, so both outputs follow the inputs within the same cycle. It does not decode which amount source an instruction uses: the caller drives a select line for that. It holds no flag state: the caller supplies the current carry and decides whether to keep the carry that comes back.

Shift kind codes on `kind_i` are LSL=0, LSR=1, ASR=2, ROR=3 and RRX=4. Codes 5 to 7 are reserved.

Top module: `sh_top`

## Requirements
- R1: For kind code 0 (logical left) and an effective amount n with 1 ≤ n ≤ 31, `result_o` is `value_i` shifted left with zeros entering at bit 0, and `carry_o` is `value_i[32-n]`.
- R2: For kind code 1 (logical right) and 1 ≤ n ≤ 31, `result_o` is `value_i` shifted right with zeros entering at bit 31, and `carry_o` is `value_i[n-1]`.
- R3: For kind code 2 (arithmetic right) and 1 ≤ n ≤ 31, the vacated upper bits take copies of `value_i[31]`, and `carry_o` is `value_i[n-1]`.
- R4: For kind code 3 (rotate right) and 1 ≤ n ≤ 31, the bits leaving bit 0 re-enter at bit 31, and `carry_o` is `value_i[n-1]`. The number of ones in the word is preserved.
- R5: For kind code 4 (rotate through carry), `result_o` is `{carry_i, value_i[31:1]}` and `carry_o` is `value_i[0]`, whatever either amount input holds.
- R6: When the effective amount is zero, or when the kind code is 5, 6 or 7, `result_o` equals `value_i` and `carry_o` equals `carry_i`.
- R7: With `amt_sel_i`=1 and kind code 0, 1 or 2, only `reg_amt_i[7:0]` forms the amount. A register amount of 256+k acts as k.
- R8: Kind codes 3 and 4 always take the amount from `imm_amt_i`, even when `amt_sel_i`=1.
- R9: Logical left or right by exactly 32 gives a zero result. `carry_o` is `value_i[0]` for the left shift and `value_i[31]` for the right shift.
- R10: Logical left or right by 33 to 255 gives a zero result with `carry_o`=0.
- R11: Arithmetic right by 32 to 255 sets every result bit, and `carry_o`, to `value_i[31]`.
- R12: Both outputs reflect a change on any input within the same clock cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| kind_i | input | 3 | Shift kind code (0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX, 5-7 reserved) |
| amt_sel_i | input | 1 | 1 selects the register amount, 0 the immediate amount |
| imm_amt_i | input | 5 | Immediate shift amount, 0 to 31 |
| reg_amt_i | input | 32 | Register holding the shift amount; low byte used |
| value_i | input | 32 | Operand to shift |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
There is no register anywhere on the path, so every result is due in the same cycle its inputs change, zero cycles later. The bench drives a new input set just after a rising edge and compares both outputs with its bit-by-bit stepping model at the following falling edge. By then the combinational outputs have settled half a period earlier, and no later edge can have altered them. Each cycle carries exactly one stimulus, so each comparison belongs to a single vector and its requirement tag.

// File: rtl/sh_pkg.sv
package sh_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned AMT_W  = 8;

    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shift_kind_e;

    typedef struct packed {
        logic [AMT_W-1:0] amt;
        logic             amt_zero;
        logic             amt_wide;
        logic             kind_ok;
    } amt_info_t;

    function automatic logic kind_known(input logic [2:0] k);
        return k <= 3'd4;
    endfunction

    function automatic logic kind_takes_reg(input logic [2:0] k);
        return (k == SK_LSL) || (k == SK_LSR) || (k == SK_ASR);
    endfunction

endpackage

// File: rtl/sh_amount_sel.sv
module sh_amount_sel
    import sh_pkg::*;
#(
    parameter int unsigned W     = DATA_W,
    parameter int unsigned AW    = AMT_W,
    parameter int unsigned IMM_W = $clog2(W)
) (
    input  logic [2:0]       kind_i,
    input  logic             amt_sel_i,
    input  logic [IMM_W-1:0] imm_amt_i,
    input  logic [AW-1:0]    reg_lo_i,
    output amt_info_t        info_o
);
    localparam logic [AW-1:0] WIDTH_AMT = AW'(W);

    logic [AW-1:0] picked;

    always_comb begin
        if (amt_sel_i && kind_takes_reg(kind_i)) begin
            picked = reg_lo_i;
        end else begin
            picked = AW'(imm_amt_i);
        end
        info_o.amt      = picked;
        info_o.amt_zero = (picked == '0);
        info_o.amt_wide = (picked >= WIDTH_AMT);
        info_o.kind_ok  = kind_known(kind_i);
    end
endmodule

// File: rtl/sh_rot_core.sv
module sh_rot_core
    import sh_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned SW = $clog2(W)
) (
    input  logic [2:0]    kind_i,
    input  logic [SW-1:0] n_i,
    input  logic [W-1:0]  value_i,
    output logic [W-1:0]  shifted_o,
    output logic          last_o
);
    logic          go_left;
    logic [SW-1:0] rot_n;
    logic [W-1:0]  stage [SW+1];
    logic [W-1:0]  rot;
    logic [W-1:0]  rmask;
    logic [W-1:0]  lmask;
    logic [W-1:0]  fill;

    assign go_left = (kind_i == SK_LSL);
    assign rot_n   = go_left ? (~n_i + 1'b1) : n_i;

    assign stage[0] = value_i;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int unsigned D = 1 << s;
        assign stage[s+1] = rot_n[s] ? {stage[s][D-1:0], stage[s][W-1:D]}
                                     : stage[s];
    end

    assign rot   = stage[SW];
    assign rmask = {W{1'b1}} >> n_i;
    assign lmask = {W{1'b1}} << n_i;
    assign fill  = (kind_i == SK_ASR) ? {W{value_i[W-1]}} : '0;

    always_comb begin
        unique case (kind_i)
            SK_LSL: begin
                shifted_o = rot & lmask;
                last_o    = rot[0];
            end
            SK_LSR, SK_ASR: begin
                shifted_o = (rot & rmask) | (fill & ~rmask);
                last_o    = rot[W-1];
            end
            default: begin
                shifted_o = rot;
                last_o    = rot[W-1];
            end
        endcase
    end
endmodule

// File: rtl/sh_out_sel.sv
module sh_out_sel
    import sh_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned AW = AMT_W
) (
    input  logic [2:0]   kind_i,
    input  amt_info_t    info_i,
    input  logic [W-1:0] value_i,
    input  logic         carry_i,
    input  logic [W-1:0] core_val_i,
    input  logic         core_last_i,
    output logic [W-1:0] result_o,
    output logic         carry_o
);
    localparam logic [AW-1:0] WIDTH_AMT = AW'(W);

    logic         exact_w;
    logic [W-1:0] wide_val;
    logic         wide_c;

    assign exact_w = (info_i.amt == WIDTH_AMT);

    always_comb begin
        wide_val = '0;
        wide_c   = 1'b0;
        unique case (kind_i)
            SK_LSL: wide_c = exact_w & value_i[0];
            SK_LSR: wide_c = exact_w & value_i[W-1];
            SK_ASR: begin
                wide_val = {W{value_i[W-1]}};
                wide_c   = value_i[W-1];
            end
            default: ;
        endcase
    end

    always_comb begin
        if (!info_i.kind_ok || (kind_i != SK_RRX && info_i.amt_zero)) begin
            result_o = value_i;
            carry_o  = carry_i;
        end else if (kind_i == SK_RRX) begin
            result_o = {carry_i, value_i[W-1:1]};
            carry_o  = value_i[0];
        end else if (info_i.amt_wide) begin
            result_o = wide_val;
            carry_o  = wide_c;
        end else begin
            result_o = core_val_i;
            carry_o  = core_last_i;
        end
    end
endmodule

// File: rtl/sh_top.sv
module sh_top
    import sh_pkg::*;
#(
    parameter int unsigned W     = DATA_W,
    parameter int unsigned AW    = AMT_W,
    parameter int unsigned IMM_W = $clog2(W)
) (
    input  logic [2:0]       kind_i,
    input  logic             amt_sel_i,
    input  logic [IMM_W-1:0] imm_amt_i,
    input  logic [W-1:0]     reg_amt_i,
    input  logic [W-1:0]     value_i,
    input  logic             carry_i,
    output logic [W-1:0]     result_o,
    output logic             carry_o
);
    amt_info_t    info;
    logic [W-1:0] core_val;
    logic         core_last;

    sh_amount_sel #(.W(W), .AW(AW), .IMM_W(IMM_W)) u_amt (
        .kind_i    (kind_i),
        .amt_sel_i (amt_sel_i),
        .imm_amt_i (imm_amt_i),
        .reg_lo_i  (reg_amt_i[AW-1:0]),
        .info_o    (info)
    );

    sh_rot_core #(.W(W), .SW(IMM_W)) u_core (
        .kind_i    (kind_i),
        .n_i       (info.amt[IMM_W-1:0]),
        .value_i   (value_i),
        .shifted_o (core_val),
        .last_o    (core_last)
    );

    sh_out_sel #(.W(W), .AW(AW)) u_out (
        .kind_i      (kind_i),
        .info_i      (info),
        .value_i     (value_i),
        .carry_i     (carry_i),
        .core_val_i  (core_val),
        .core_last_i (core_last),
        .result_o    (result_o),
        .carry_o     (carry_o)
    );
endmodule

// File: rtl/sh_chk.sv
module sh_chk #(
    parameter int unsigned W     = 32,
    parameter int unsigned AW    = 8,
    parameter int unsigned IMM_W = $clog2(W)
) (
    input logic [2:0]       kind_i,
    input logic             amt_sel_i,
    input logic [IMM_W-1:0] imm_amt_i,
    input logic [W-1:0]     reg_amt_i,
    input logic [W-1:0]     value_i,
    input logic             carry_i,
    input logic [W-1:0]     result_o,
    input logic             carry_o
);
    int eff;

    always_comb begin
        if (amt_sel_i && kind_i <= 3'd2) eff = int'(reg_amt_i[AW-1:0]);
        else                             eff = int'(imm_amt_i);

        if (kind_i > 3'd4 || (kind_i != 3'd4 && eff == 0))
            AST_ZERO_PASS: assert (result_o == value_i && carry_o == carry_i); // R6
        if (kind_i == 3'd4)
            AST_RRX_TOP: assert (result_o[W-1] == carry_i && carry_o == value_i[0]
                                 && result_o[W-2:0] == value_i[W-1:1]); // R5
        if (kind_i <= 3'd1 && eff > W)
            AST_LOGIC_BEYOND: assert (result_o == '0 && !carry_o); // R10
        if (kind_i == 3'd1 && eff == W)
            AST_LSR_EXACT: assert (result_o == '0 && carry_o == value_i[W-1]); // R9
        if (kind_i == 3'd2 && eff >= W)
            AST_ASR_SATURATE: assert (result_o == {W{value_i[W-1]}}
                                      && carry_o == value_i[W-1]); // R11
        if (kind_i == 3'd3)
            AST_ROR_ONES: assert ($countones(result_o) == $countones(value_i)); // R4
    end
endmodule

bind sh_top sh_chk #(.W(W), .AW(AW), .IMM_W(IMM_W)) u_chk (
    .kind_i    (kind_i),
    .amt_sel_i (amt_sel_i),
    .imm_amt_i (imm_amt_i),
    .reg_amt_i (reg_amt_i),
    .value_i   (value_i),
    .carry_i   (carry_i),
    .result_o  (result_o),
    .carry_o   (carry_o)
);

// File: tb/sim_sh_top.sv
`timescale 1ns/1ps
module sim_sh_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  kind;
    logic        sel;
    logic [4:0]  imm;
    logic [31:0] ramt;
    logic [31:0] val;
    logic        cin;
    logic [31:0] res;
    logic        cout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sh_top u0 (
        .kind_i    (kind),
        .amt_sel_i (sel),
        .imm_amt_i (imm),
        .reg_amt_i (ramt),
        .value_i   (val),
        .carry_i   (cin),
        .result_o  (res),
        .carry_o   (cout)
    );

    // Stepping model: one bit position per iteration.
    task automatic model(input logic [2:0] k, input logic s, input logic [4:0] im,
                         input logic [31:0] ra, input logic [31:0] v_in, input logic c_in,
                         output logic [31:0] v, output logic c);
        int n;
        v = v_in;
        c = c_in;
        if (s && k <= 3'd2) n = int'(ra % 256);
        else                n = int'(im);
        if (k == 3'd4) begin
            c = v_in[0];
            v = {c_in, v_in[31:1]};
        end else if (k <= 3'd3) begin
            for (int i = 0; i < n; i++) begin
                case (k)
                    3'd0: begin c = v[31]; v = v << 1; end
                    3'd1: begin c = v[0];  v = v >> 1; end
                    3'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
                    default: begin c = v[0]; v = {v[0], v[31:1]}; end
                endcase
            end
        end
    endtask

    task automatic apply(input logic [2:0] k, input logic s, input logic [4:0] im,
                         input logic [31:0] ra, input logic [31:0] v_in, input logic c_in,
                         input string tag);
        logic [31:0] ev;
        logic        ec;
        @(posedge clk);
        #1;
        kind = k; sel = s; imm = im; ramt = ra; val = v_in; cin = c_in;
        @(negedge clk);
        model(k, s, im, ra, v_in, c_in, ev, ec);
        checks++;
        if (res !== ev || cout !== ec) begin
            fails++;
            $display("FAIL %s kind=%0d sel=%0b imm=%0d reg=%h val=%h cin=%0b actual=%h/%0b expected=%h/%0b",
                     tag, k, s, im, ra, v_in, c_in, res, cout, ev, ec);
        end
    endtask

    function automatic string tag_of(input logic [2:0] k, input logic s,
                                     input logic [4:0] im, input logic [31:0] ra);
        int n;
        if (s && k <= 3'd2) n = int'(ra % 256); else n = int'(im);
        if (k > 3'd4)                 return "R6";
        if (k == 3'd4)                return "R5";
        if (n == 0)                   return "R6";
        if (k == 3'd3)                return "R4";
        if (k == 3'd2 && n >= 32)     return "R11";
        if (n == 32)                  return "R9";
        if (n > 32)                   return "R10";
        if (k == 3'd0)                return "R1";
        if (k == 3'd1)                return "R2";
        return "R3";
    endfunction

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL R12 watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        kind = '0; sel = 1'b0; imm = '0; ramt = '0; val = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Reset-time idle inputs: zero value, zero amount (R6)
        @(negedge clk);
        checks++;
        if (res !== 32'h0 || cout !== 1'b0) begin
            fails++;
            $display("FAIL R6 idle actual=%h/%0b expected=00000000/0", res, cout);
        end

        apply(3'd0, 1'b0, 5'd1,  0, 32'h8000_0001, 1'b0, "R1");
        apply(3'd0, 1'b0, 5'd31, 0, 32'h0000_0003, 1'b0, "R1");
        apply(3'd1, 1'b0, 5'd4,  0, 32'hF000_000F, 1'b0, "R2");
        apply(3'd1, 1'b1, 5'd0,  31, 32'h8000_0000, 1'b1, "R2");
        apply(3'd2, 1'b0, 5'd8,  0, 32'h8000_0080, 1'b0, "R3");
        apply(3'd2, 1'b1, 5'd0,  3, 32'h7FFF_FFFC, 1'b1, "R3");
        apply(3'd3, 1'b0, 5'd8,  0, 32'h1234_5678, 1'b0, "R4");
        apply(3'd3, 1'b0, 5'd31, 0, 32'h0000_0001, 1'b0, "R4");
        apply(3'd4, 1'b0, 5'd0,  0, 32'h0000_0003, 1'b1, "R5");
        apply(3'd4, 1'b1, 5'd17, 200, 32'hFFFF_FFFE, 1'b0, "R5");
        apply(3'd0, 1'b0, 5'd0,  0, 32'hDEAD_BEEF, 1'b1, "R6");
        apply(3'd2, 1'b1, 5'd9,  0, 32'hDEAD_BEEF, 1'b0, "R6");
        apply(3'd6, 1'b1, 5'd5,  7, 32'hCAFE_F00D, 1'b1, "R6");
        apply(3'd1, 1'b1, 5'd0,  32'h0000_0104, 32'h0000_00F0, 1'b0, "R7");
        apply(3'd0, 1'b1, 5'd0,  32'hFFFF_FF00, 32'h1234_5678, 1'b1, "R7");
        apply(3'd3, 1'b1, 5'd4,  32'd9, 32'h0000_000F, 1'b0, "R8");
        apply(3'd4, 1'b1, 5'd3,  32'd1, 32'h0000_0000, 1'b1, "R8");
        apply(3'd0, 1'b1, 5'd0,  32, 32'h0000_0001, 1'b0, "R9");
        apply(3'd1, 1'b1, 5'd0,  32, 32'h8000_0000, 1'b0, "R9");
        apply(3'd0, 1'b1, 5'd0,  33, 32'hFFFF_FFFF, 1'b1, "R10");
        apply(3'd1, 1'b1, 5'd0,  255, 32'hFFFF_FFFF, 1'b1, "R10");
        apply(3'd2, 1'b1, 5'd0,  32, 32'h8000_0000, 1'b0, "R11");
        apply(3'd2, 1'b1, 5'd0,  200, 32'h7FFF_FFFF, 1'b1, "R11");

        // Back-to-back changes: outputs must follow each new vector (R12)
        for (int i = 0; i < 400; i++) begin
            logic [2:0]  k  = 3'($urandom_range(0, 7));
            logic        s  = 1'($urandom);
            logic [4:0]  im = 5'($urandom);
            logic [31:0] ra = (i % 3 == 0) ? 32'($urandom_range(0, 70)) : $urandom;
            apply(k, s, im, ra, $urandom, 1'($urandom), tag_of(k, s, im, ra));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule